// File: doc/BRIEF.md
# Optical Packet Deframer

This block receives a compact CAN-style frame sent serially over an optical link that uses two light wavelengths. The receiver front end gives two sampled lines. `rx_bit` carries the data value. `rx_agree` is high when both light channels show the same level. A slow bit-rate tick paces the whole block. The working rate is in the low hundreds of hertz, so one tick arrives every many thousands of system clocks.

Frame boundaries are found upstream and arrive as one-tick flags. After a start flag, the block shifts in the following fields in this order:

1. An identifier.
2. A length code.
3. A data field of one to sixteen bytes.
4. A 15-bit CAN CRC.

The frame has no remote-request bit and no acknowledge slot. After the CRC checks out, the block waits for the stop flag and then pulses `frame_valid`. Any sampled field bit on which the two channels disagree aborts the frame and sets a false-signal flag. A CRC mismatch aborts the frame and sets a CRC flag.

Clearing is split in two. A buffer clear wipes the identifier and data registers when a frame starts and when a frame aborts. A state clear resets the CRC engine and the captured CRC whenever a frame starts, ends or aborts. The identifier, length code, data words and flags are registered and can be read by a processor.

Top module: `optical_deframer`

## Requirements
- R1: After a synchronous reset, `rx_id`, `rx_len`, `rx_data`, `false_err`, `crc_err` and `frame_valid` are all zero.
- R2: A frame begins only on a tick in which `start_flag` is high while the block is idle. A start flag during a frame is ignored. Idle ticks without a start flag change no output.
- R3: After the start tick, the next ID_W ticks shift the identifier into `rx_id`, most significant bit first. The next LEN_W ticks shift the length code into `rx_len`, MSB first.
- R4: A length code n selects (n+1)*8 data bits. The data bit received at index i (counting from 0) is stored in word i/WORD_W, at bit WORD_W-1-(i mod WORD_W). Word k occupies `rx_data[k*WORD_W +: WORD_W]`. Unreceived words stay zero.
- R5: The CRC is computed with a zero seed and polynomial CRC_POLY (default 0x4599) over the identifier, length and data bits. Each step computes f = bit XOR crc[MSB], then crc = (crc<<1) XOR (f ? CRC_POLY : 0). The next CRC_W ticks carry the sent CRC, MSB first. On a mismatch, `crc_err` is set, `rx_id` and `rx_data` are cleared, and the block returns to idle.
- R6: A tick in any field (identifier, length, data or CRC) with `rx_agree` low sets `false_err`, clears `rx_id` and `rx_data`, and returns the block to idle.
- R7: After a correct CRC, the block waits. On a tick with `stop_flag` high, `frame_valid` is high for exactly one clock, and only with both error flags low.
- R8: The start tick of a new frame clears `false_err`, `crc_err`, `rx_id` and `rx_data`.
- R9: Clocks without `bit_tick` change no output, whatever the other inputs do.
- R10: While waiting for the stop flag, ticks with `rx_agree` low or without `stop_flag` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock bit-rate enable |
| rx_bit | input | 1 | Sampled data level |
| rx_agree | input | 1 | High when both optical channels agree |
| start_flag | input | 1 | Start boundary seen (sampled on a tick) |
| stop_flag | input | 1 | Stop boundary seen (sampled on a tick) |
| rx_id | output | ID_W | Received identifier |
| rx_len | output | LEN_W | Received length code |
| rx_data | output | 8<<LEN_W | Data buffer, word k at bits k*WORD_W upward |
| false_err | output | 1 | Channel disagreement seen in a field |
| crc_err | output | 1 | CRC mismatch |
| frame_valid | output | 1 | One-clock pulse for a good frame |

## Verification
The bench builds the block with a 5-bit identifier, a 2-bit length code (a 32-bit buffer of four 8-bit words) and the default 15-bit CRC. With these values, every identifier paired with every length code can be sent as a good frame. A disagreement can also be injected at every bit position of one frame, and a flip tried on every CRC bit, in a short run. Expected data words and CRC values are worked out arithmetically in the bench. The idle clocks between ticks carry conflicting levels on every input, to show that only ticks matter.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_LEN, ST_DATA, ST_CRC, ST_STOP
  } dfr_state_e;
endpackage

// File: rtl/dfr_crc.sv
module dfr_crc #(
  parameter int CRC_W = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  logic fb;
  assign fb = din ^ crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (en)    crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/dfr_ctrl.sv
module dfr_ctrl
  import dfr_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int LEN_W = 4,
  parameter int CRC_W = 15,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bit_in,
  input  logic             agree_in,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CRC_W-1:0] crc_calc,
  output logic             new_frame,
  output logic             pre_clr,
  output logic             com_clr,
  output logic             crc_en,
  output logic             id_we,
  output logic             len_we,
  output logic             data_we,
  output logic [CNT_W-1:0] data_idx,
  output logic             set_false,
  output logic             set_crc_err,
  output logic             done_o
);
  dfr_state_e       st;
  logic [CNT_W-1:0] cnt, last_cnt;
  logic [CRC_W-1:0] crc_rx, crc_word;
  logic             in_field, field_last, good;

  assign in_field = (st == ST_ID) || (st == ST_LEN) || (st == ST_DATA) || (st == ST_CRC);

  always_comb begin
    case (st)
      ST_ID:   last_cnt = CNT_W'(ID_W - 1);
      ST_LEN:  last_cnt = CNT_W'(LEN_W - 1);
      ST_DATA: last_cnt = CNT_W'({len_i, 3'b111});
      ST_CRC:  last_cnt = CNT_W'(CRC_W - 1);
      default: last_cnt = '0;
    endcase
  end

  assign field_last  = (cnt == last_cnt);
  assign good        = tick && in_field && agree_in;
  assign crc_word    = {crc_rx[CRC_W-2:0], bit_in};
  assign new_frame   = tick && (st == ST_IDLE) && start_in;
  assign set_false   = tick && in_field && !agree_in;
  assign set_crc_err = good && (st == ST_CRC) && field_last && (crc_word != crc_calc);
  assign done_o      = tick && (st == ST_STOP) && stop_in;
  assign pre_clr     = new_frame || set_false || set_crc_err;
  assign com_clr     = pre_clr || done_o;
  assign crc_en      = good && (st != ST_CRC);
  assign id_we       = good && (st == ST_ID);
  assign len_we      = good && (st == ST_LEN);
  assign data_we     = good && (st == ST_DATA);
  assign data_idx    = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        ST_IDLE: if (start_in) begin st <= ST_ID; cnt <= '0; end
        ST_STOP: if (stop_in) st <= ST_IDLE;
        default: begin
          if (!agree_in) begin
            st <= ST_IDLE; cnt <= '0;
          end else if (field_last) begin
            cnt <= '0;
            case (st)
              ST_ID:   st <= ST_LEN;
              ST_LEN:  st <= ST_DATA;
              ST_DATA: st <= ST_CRC;
              default: st <= (crc_word == crc_calc) ? ST_STOP : ST_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || com_clr)             crc_rx <= '0;
    else if (good && st == ST_CRC)  crc_rx <= crc_word;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(tick && start_in)) |=> st == ST_IDLE);
  // R4
  field_bound_chk: assert property (@(posedge clk) disable iff (rst)
    in_field |-> cnt <= last_cnt);
  // R10
  stop_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && !(tick && stop_in)) |=> st == ST_STOP);
endmodule

// File: rtl/dfr_store.sv
module dfr_store #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     new_frame,
  input  logic                     pre_clr,
  input  logic                     id_we,
  input  logic                     len_we,
  input  logic                     data_we,
  input  logic [CNT_W-1:0]         data_idx,
  input  logic                     bit_in,
  input  logic                     set_false,
  input  logic                     set_crc_err,
  input  logic                     done_i,
  output logic [ID_W-1:0]          id_q,
  output logic [LEN_W-1:0]         len_q,
  output logic [(8<<LEN_W)-1:0]    data_o,
  output logic                     false_q,
  output logic                     crc_q,
  output logic                     valid_q
);
  localparam int DATA_W = 8 << LEN_W;
  localparam int NWORDS = DATA_W / WORD_W;
  localparam int BOFF_W = $clog2(WORD_W);
  localparam int WIDX_W = CNT_W - BOFF_W;

  logic [NWORDS-1:0][WORD_W-1:0] data_q;
  logic [BOFF_W-1:0]             boff, bpos;
  logic [WIDX_W-1:0]             widx;

  assign boff   = data_idx[BOFF_W-1:0];
  assign bpos   = ~boff;
  assign widx   = data_idx[CNT_W-1:BOFF_W];
  assign data_o = data_q;

  always_ff @(posedge clk) begin
    if (rst || pre_clr) id_q <= '0;
    else if (id_we)     id_q <= {id_q[ID_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (len_we) len_q <= {len_q[LEN_W-2:0], bit_in};
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || pre_clr)
        data_q[w] <= '0;
      else if (data_we && widx == WIDX_W'(w))
        data_q[w][bpos] <= bit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || new_frame) begin
      false_q <= 1'b0;
      crc_q   <= 1'b0;
    end else begin
      if (set_false)   false_q <= 1'b1;
      if (set_crc_err) crc_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= done_i;
  end

  // R6
  buf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pre_clr |=> data_o == '0);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/optical_deframer.sv
module optical_deframer #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 32,
  parameter int CRC_W  = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_tick,
  input  logic                  rx_bit,
  input  logic                  rx_agree,
  input  logic                  start_flag,
  input  logic                  stop_flag,
  output logic [ID_W-1:0]       rx_id,
  output logic [LEN_W-1:0]      rx_len,
  output logic [(8<<LEN_W)-1:0] rx_data,
  output logic                  false_err,
  output logic                  crc_err,
  output logic                  frame_valid
);
  localparam int DATA_W = 8 << LEN_W;
  localparam int MAXF   = (DATA_W > ID_W) ? ((DATA_W > CRC_W) ? DATA_W : CRC_W)
                                          : ((ID_W > CRC_W) ? ID_W : CRC_W);
  localparam int CNT_W  = $clog2(MAXF + 1);

  logic             new_frame, pre_clr, com_clr, crc_en;
  logic             id_we, len_we, data_we, set_false, set_crc_err, done;
  logic [CNT_W-1:0] data_idx;
  logic [CRC_W-1:0] crc_calc;

  dfr_ctrl #(.ID_W(ID_W), .LEN_W(LEN_W), .CRC_W(CRC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(bit_tick), .bit_in(rx_bit), .agree_in(rx_agree),
    .start_in(start_flag), .stop_in(stop_flag), .len_i(rx_len), .crc_calc(crc_calc),
    .new_frame(new_frame), .pre_clr(pre_clr), .com_clr(com_clr), .crc_en(crc_en),
    .id_we(id_we), .len_we(len_we), .data_we(data_we), .data_idx(data_idx),
    .set_false(set_false), .set_crc_err(set_crc_err), .done_o(done)
  );

  dfr_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(com_clr), .en(crc_en), .din(rx_bit), .crc_q(crc_calc)
  );

  dfr_store #(.ID_W(ID_W), .LEN_W(LEN_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .new_frame(new_frame), .pre_clr(pre_clr),
    .id_we(id_we), .len_we(len_we), .data_we(data_we), .data_idx(data_idx),
    .bit_in(rx_bit), .set_false(set_false), .set_crc_err(set_crc_err), .done_i(done),
    .id_q(rx_id), .len_q(rx_len), .data_o(rx_data), .false_q(false_err),
    .crc_q(crc_err), .valid_q(frame_valid)
  );

  // R6
  false_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(false_err) |-> $past(bit_tick && !rx_agree));
  // R7
  valid_clean_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> !false_err && !crc_err);
  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(rx_id) && $stable(rx_data) && $stable(rx_len) && !frame_valid);
endmodule

// File: tb/tb_optical_deframer.sv
module tb_optical_deframer;
  localparam int ID_W = 5, LEN_W = 2, WORD_W = 8, CRC_W = 15;
  localparam logic [14:0] POLY = 15'h4599;

  logic clk = 0, rst = 1, bit_tick = 0, rx_bit = 0, rx_agree = 0;
  logic start_flag = 0, stop_flag = 0;
  logic [ID_W-1:0] rx_id;
  logic [LEN_W-1:0] rx_len;
  logic [31:0] rx_data;
  logic false_err, crc_err, frame_valid;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic bits [0:255];

  always #4 clk = ~clk;

  optical_deframer #(.ID_W(ID_W), .LEN_W(LEN_W), .WORD_W(WORD_W), .CRC_W(CRC_W),
                     .CRC_POLY(POLY)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit), .rx_agree(rx_agree),
    .start_flag(start_flag), .stop_flag(stop_flag), .rx_id(rx_id), .rx_len(rx_len),
    .rx_data(rx_data), .false_err(false_err), .crc_err(crc_err), .frame_valid(frame_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input logic s, input logic m, input logic sa, input logic sp);
    @(negedge clk);
    rx_bit = s; rx_agree = m; start_flag = sa; stop_flag = sp; bit_tick = 1;
    @(negedge clk);
    bit_tick = 0; rx_bit = ~s; rx_agree = ~m; start_flag = 1; stop_flag = 1;
  endtask

  function automatic logic [14:0] crc_of(input int n);
    logic [14:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb = bits[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [7:0] byte_of(input int id, input int lc, input int b);
    return 8'((id * 7 + b * 13 + lc * 5 + 1) & 8'hff);
  endfunction

  // mode 0: good frame; 1: disagreement at bit pos; 2: flip CRC bit pos
  task automatic send_frame(input int id, input int lc, input int mode, input int pos);
    int k = 0, pay, total;
    logic [14:0] c;
    logic [31:0] exp_data = '0;
    for (int i = ID_W - 1; i >= 0; i--) begin bits[k] = id[i]; k++; end
    for (int i = LEN_W - 1; i >= 0; i--) begin bits[k] = lc[i]; k++; end
    for (int b = 0; b <= lc; b++) begin
      logic [7:0] v = byte_of(id, lc, b);
      exp_data[b*8 +: 8] = v;
      for (int j = 7; j >= 0; j--) begin bits[k] = v[j]; k++; end
    end
    pay = k;
    c = crc_of(pay);
    for (int i = 14; i >= 0; i--) begin bits[k] = c[i]; k++; end
    total = k;
    if (mode == 2) bits[pay + pos] = ~bits[pay + pos];

    tk(0, 1, 1, 0);
    // R8: start tick clears flags, ID and data
    chk("R8 flags", {62'd0, false_err, crc_err}, 64'd0);
    chk("R8 id/data", {rx_id, rx_data}, 64'd0);

    for (int i = 0; i < total; i++) begin
      logic bad = (mode == 1) && (i == pos);
      // R2: start flag inside a frame is ignored
      tk(bits[i], !bad, (id % 2 == 1) && (i == ID_W), 0);
      if (bad) begin
        chk("R6 false_err", {63'd0, false_err}, 64'd1);
        chk("R6 id/data cleared", {rx_id, rx_data}, 64'd0);
        chk("R6 no crc_err", {63'd0, crc_err}, 64'd0);
        tk(0, 0, 0, 0);
        chk("R6 stays idle", {62'd0, false_err, frame_valid}, 64'd2);
        tk(0, 1, 0, 1);
        chk("R6 no valid", {63'd0, frame_valid}, 64'd0);
        return;
      end
    end

    if (mode == 2) begin
      chk("R5 crc_err", {63'd0, crc_err}, 64'd1);
      chk("R5 id/data cleared", {rx_id, rx_data}, 64'd0);
      tk(0, 1, 0, 1);
      chk("R5 no valid", {63'd0, frame_valid}, 64'd0);
      return;
    end

    chk("R3 id", 64'(rx_id), 64'(id));
    chk("R3 len", 64'(rx_len), 64'(lc));
    chk("R4 data", 64'(rx_data), 64'(exp_data));
    chk("R5 no error", {62'd0, false_err, crc_err}, 64'd0);
    if (id % 4 == 0) begin
      tk(1, 0, 0, 0);
      chk("R10 wait ignores disagreement", {62'd0, false_err, frame_valid}, 64'd0);
    end
    tk(0, 1, 0, 1);
    chk("R7 valid", {63'd0, frame_valid}, 64'd1);
    @(negedge clk);
    chk("R7 single pulse", {63'd0, frame_valid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {rx_id, rx_len, rx_data, false_err, crc_err, frame_valid}, 64'd0);

    // R2: ticks in idle without start change nothing
    for (int i = 0; i < 4; i++) tk(i[0], i[1], 0, 1);
    chk("R2 idle ticks", {rx_id, rx_len, rx_data, false_err, crc_err, frame_valid}, 64'd0);

    for (int id = 0; id < 32; id++)
      for (int lc = 0; lc < 4; lc++) send_frame(id, lc, 0, 0);

    // R9: clocks without tick leave outputs alone
    repeat (5) begin
      @(negedge clk);
      rx_agree = 0; start_flag = 1; stop_flag = 1; rx_bit = ~rx_bit;
    end
    chk("R9 no tick hold", {rx_id, rx_len, frame_valid}, {57'd0, 5'd31, 2'd3, 1'b0});
    chk("R9 no tick data", 64'(rx_data), 64'({byte_of(31, 3, 3), byte_of(31, 3, 2),
                                               byte_of(31, 3, 1), byte_of(31, 3, 0)}));

    for (int p = 0; p < ID_W + LEN_W + 16 + CRC_W; p++) send_frame(21, 1, 1, p);
    for (int p = 0; p < CRC_W; p++) send_frame(9, 3, 2, p);
    send_frame(12, 2, 0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule